// File: doc/BRIEF.md
# Functional Broadside Test Pattern Controller

This block generates two-pattern delay tests for a sequential circuit without ever loading an arbitrary state into its flip-flops. On a start request it first pulses a reset to the circuit under test, which puts it in a known initial state. It then applies a pseudo-random input sequence of fixed length, one vector per clock. Because every state the circuit passes through is reached by functional operation from reset, every one of those states is a legal scan-in state.

The vectors come from a linear feedback shift register of N+MOD bits. The upper N bits supply the circuit inputs. The lower MOD bits drive a small gate network that flips each input bit through its own function, which breaks up the correlation between inputs and keeps the circuit from settling into the same few states. A single AND gate on two register bits marks some time units as test points. The test taken at time unit u uses the state reached at u, the vector a(u) and the vector a(u+1).

The seed can be rewritten between runs, so one fixed structure yields many sequences and test subsets.

Top module: `broadside_tpg`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, every output is 0. The stored seed and the register both hold DEFAULT_SEED (default 7'h2B).
- R2: When start is high at an edge while idle, circuit_init is high for exactly the next cycle. pattern_active is then high for exactly L cycles (default 16), which are time units u = 0..L-1.
- R3: At a start edge the W=N+MOD bit register (default 7 bits) is loaded from the stored seed. It holds that value during time unit 0. After each active cycle it shifts left by one, and bit 0 takes the XOR of the bits selected by TAPS (default bits 6 and 5).
- R4: During an active cycle, pattern[i] = reg[MOD+i] XOR (reg[i mod MOD] AND reg[(i+1) mod MOD]). When pattern_active is low, pattern is 0.
- R5: launch_valid is high in time unit u+1 exactly when reg[SEL_A] AND reg[SEL_B] (defaults bit 6 and bit 0) held during time unit u, for u < L-1. The last time unit never selects.
- R6: capture is high exactly one cycle after each launch_valid cycle, including after the last time unit.
- R7: done rises in the cycle after time unit L-1. It stays high until the next accepted start, and then it clears in the circuit_init cycle.
- R8: seed_wr while idle, with start low, stores seed_in, except that a zero value stores DEFAULT_SEED. seed_wr while busy, or in the same cycle as an accepted start, has no effect.
- R9: A second run with an unchanged stored seed reproduces the same pattern sequence and the same test selections.
- R10: start while circuit_init or pattern_active is high has no effect. The run still lasts exactly L active cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a run when idle |
| seed_wr | input | 1 | store seed_in when idle |
| seed_in | input | N+MOD | new seed value |
| circuit_init | output | 1 | reset pulse to the circuit under test |
| pattern_active | output | 1 | pattern carries a(u) this cycle |
| pattern | output | N | primary input vector to the circuit |
| launch_valid | output | 1 | a(u+1) of a selected test is applied now |
| capture | output | 1 | capture strobe for the selected test |
| done | output | 1 | run finished |

## Verification
Each result has a fixed latency from the edge that starts it:
- circuit_init follows an accepted start by one cycle, and time unit 0 follows one cycle after that.
- pattern is combinational from the register during its time unit.
- launch_valid comes one cycle after the time unit that selected it, and capture one cycle after launch_valid.
- done comes one cycle after the last time unit.

The bench keeps a behavioural model that advances on the rising edge with the same input values. It compares every output against that model at the falling edge, so each expected value lines up with the cycle in which it is due. Whole-run sequences are also stored and compared across runs for the reseed and repeat cases.

// File: rtl/broadside_tpg.sv
module broadside_tpg #(
  parameter int N = 4,
  parameter int MOD = 3,
  parameter int L = 16,
  parameter logic [N+MOD-1:0] TAPS = 7'b1100000,
  parameter logic [N+MOD-1:0] DEFAULT_SEED = 7'h2B,
  parameter int SEL_A = N + MOD - 1,
  parameter int SEL_B = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               seed_wr,
  input  logic [N+MOD-1:0]   seed_in,
  output logic               circuit_init,
  output logic               pattern_active,
  output logic [N-1:0]       pattern,
  output logic               launch_valid,
  output logic               capture,
  output logic               done
);
  localparam int W  = N + MOD;
  localparam int CW = (L > 2) ? $clog2(L) : 1;

  typedef enum logic [1:0] {IDLE, INIT, RUN} st_t;

  st_t            st;
  logic [W-1:0]   seed_q, lfsr;
  logic [CW-1:0]  idx;
  logic           sel_q, cap_q, done_q;
  logic [N-1:0]   pat_mod;

  wire          last     = (idx == CW'(L - 1));
  wire          sel_bit  = lfsr[SEL_A] & lfsr[SEL_B];
  wire [W-1:0]  lfsr_nxt = {lfsr[W-2:0], ^(lfsr & TAPS)};

  for (genvar i = 0; i < N; i++) begin : g_mod
    assign pat_mod[i] = lfsr[MOD+i] ^ (lfsr[i % MOD] & lfsr[(i + 1) % MOD]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      seed_q <= DEFAULT_SEED;
      lfsr   <= DEFAULT_SEED;
      idx    <= '0;
      sel_q  <= 1'b0;
      cap_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cap_q <= sel_q;
      sel_q <= 1'b0;
      case (st)
        IDLE: begin
          if (start) begin
            st     <= INIT;
            lfsr   <= seed_q;
            done_q <= 1'b0;
          end else if (seed_wr) begin
            seed_q <= (seed_in == '0) ? DEFAULT_SEED : seed_in;
          end
        end
        INIT: begin
          st  <= RUN;
          idx <= '0;
        end
        RUN: begin
          lfsr  <= lfsr_nxt;
          sel_q <= sel_bit & ~last;
          idx   <= idx + 1'b1;
          if (last) begin
            st     <= IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign circuit_init   = (st == INIT);
  assign pattern_active = (st == RUN);
  assign pattern        = pattern_active ? pat_mod : '0;
  assign launch_valid   = sel_q;
  assign capture        = cap_q;
  assign done           = done_q;
endmodule

module broadside_tpg_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         circuit_init,
  input logic         pattern_active,
  input logic [N-1:0] pattern,
  input logic         launch_valid,
  input logic         capture,
  input logic         done
);
  assert_init_then_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    circuit_init |=> pattern_active && !circuit_init);
  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({circuit_init, pattern_active}));
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pattern_active |-> pattern == '0);
  assert_launch_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> $past(pattern_active));
  assert_capture_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |=> capture);
  assert_capture_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> $past(launch_valid));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pattern_active && !circuit_init);
  assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pattern_active));
endmodule

bind broadside_tpg broadside_tpg_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .circuit_init(circuit_init),
  .pattern_active(pattern_active), .pattern(pattern),
  .launch_valid(launch_valid), .capture(capture), .done(done));

// File: tb/broadside_tpg_test.sv
module broadside_tpg_test;
  localparam int PERIOD = 10;
  localparam int L = 16;
  localparam logic [6:0] DEF = 7'h2B;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, seed_wr = 1'b0;
  logic [6:0] seed_in = '0;
  logic circuit_init, pattern_active, launch_valid, capture, done;
  logic [3:0] pattern;

  int checks = 0, errors = 0;
  bit finished = 0;

  broadside_tpg uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [6:0] f_next(logic [6:0] x);
    return {x[5:0], x[6] ^ x[5]};
  endfunction
  function automatic logic [3:0] f_pat(logic [6:0] x);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = x[3+i] ^ (x[i % 3] & x[(i + 1) % 3]);
    return p;
  endfunction

  int m_st, m_u;
  logic [6:0] m_seed, m_lfsr;
  bit m_sel, m_cap, m_done, nsel;
  logic [4:0] q_cur[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_u = 0; m_seed = DEF; m_lfsr = DEF;
      m_sel = 0; m_cap = 0; m_done = 0;
    end else begin
      m_cap = m_sel; nsel = 0;
      case (m_st)
        0: if (start) begin m_st = 1; m_lfsr = m_seed; m_done = 0; end
           else if (seed_wr) m_seed = (seed_in == 0) ? DEF : seed_in;
        1: begin m_st = 2; m_u = 0; end
        default: begin
          nsel = m_lfsr[6] & m_lfsr[0] & (m_u != L - 1);
          m_lfsr = f_next(m_lfsr);
          if (m_u == L - 1) begin m_st = 0; m_done = 1; end
          m_u++;
        end
      endcase
      m_sel = nsel;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 circuit_init", circuit_init, m_st == 1);
    chk("R2 pattern_active", pattern_active, m_st == 2);
    chk("R3/R4 pattern", pattern, (m_st == 2) ? f_pat(m_lfsr) : 4'h0);
    chk("R5 launch_valid", launch_valid, m_sel);
    chk("R6 capture", capture, m_cap);
    chk("R7 done", done, m_done);
    if (pattern_active) q_cur.push_back({launch_valid, pattern});
  end

  task automatic run_seq(output logic [4:0] q[$], input bit poke = 0);
    int n;
    q_cur.delete();
    start = 1; @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk); n++;
      if (poke && n == 5) begin start = 1; seed_wr = 1; seed_in = 7'h55; end
      else begin start = 0; seed_wr = 0; end
    end
    @(negedge clk);
    q = q_cur;
  endtask

  task automatic write_seed(logic [6:0] v);
    seed_wr = 1; seed_in = v; @(negedge clk); seed_wr = 0;
  endtask

  logic [4:0] q1[$], q2[$], q3[$], q4[$];

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {circuit_init, pattern_active, pattern, launch_valid, capture, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs after reset", {circuit_init, pattern_active, pattern, launch_valid, capture, done}, 0);

    run_seq(q1);
    chk("R2 run length", q1.size(), L);
    chk("R3 first vector from default seed", q1[0][3:0], f_pat(DEF));
    chk("R3 second vector", q1[1][3:0], f_pat(f_next(DEF)));
    chk("R7 done held", done, 1);

    run_seq(q2);
    chk("R9 repeat run identical", q2 == q1, 1);

    write_seed(7'h00);
    run_seq(q3);
    chk("R8 zero seed maps to default", q3 == q1, 1);

    write_seed(7'h11);
    run_seq(q4, 1);
    chk("R10 start while busy ignored, length", q4.size(), L);
    chk("R3 first vector from new seed", q4[0][3:0], f_pat(7'h11));
    run_seq(q3);
    chk("R8 seed_wr while busy ignored", q3[0][3:0], f_pat(7'h11));
    chk("R9 reseeded repeat identical", q3 == q4, 1);

    start = 1; seed_wr = 1; seed_in = 7'h7F;
    @(negedge clk); start = 0; seed_wr = 0;
    while (!done) @(negedge clk);
    run_seq(q2);
    chk("R8 seed_wr with start ignored", q2 == q4, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule